// File: doc/BRIEF.md
# CAN Fault-Confinement Error Counters with Error Log

This block holds the transmit and receive fault-confinement counters of a CAN protocol controller, together with a saturating error-log counter. A protocol engine feeds it event strobes that are already classified: transmit error, receive error, transmit success and receive success. The block turns them into counter updates, error-passive and bus-off status, and a sticky interrupt flag for log overflow. All of this state is also packed into one 32-bit status word.

A restricted-operation input stops protocol errors from raising the two fault counters, while the log counter keeps counting them. Reading the log field clears the log counter. After bus-off the node stays silent until a recovery request clears both counters.

Top module: `can_err_count`

## Requirements
- R1: After reset, all counters are zero, every flag is low, and `status_o` is zero.
- R2: A transmit error adds 8 to the transmit count while restricted mode is low and the block is not in bus-off. A transmit success with no transmit error in the same cycle subtracts 1, and the count never goes below 0.
- R3: A receive error adds 1 to the receive count while restricted mode is low and the block is not in bus-off. A receive success with no receive error in the same cycle subtracts 1, and the count never goes below 0.
- R4: The reported receive count stops at 127. A receive error at 127 sets an internal passive flag and leaves the count at 127. A receive success while the flag is set clears the flag and leaves the count at 127.
- R5: `err_passive_o` is high exactly when the transmit count is at least 128 or the receive passive flag is set.
- R6: A transmit error that would take the transmit count past 255 sets `bus_off_o` and leaves the count at 255. While in bus-off, both counters and the log counter hold. `recover_i` in bus-off clears both counters, the passive flag and bus-off. Outside bus-off, `recover_i` has no effect.
- R7: While `restrict_i` is high, errors leave the transmit and receive counts unchanged, and the log counter still increments.
- R8: In each cycle with a transmit error or a receive error outside bus-off, the log counter increments by 1. It counts once even when both errors arrive together. It holds at 0xFF and never wraps.
- R9: `rd_log_i` clears the log counter. If an increment falls in the same cycle as the read, the log counter becomes 1.
- R10: An increment while the log counter is 0xFF, with no read in that cycle, sets the sticky `elo_irq_o`. Only `elo_clr_i` clears it, and a set in the same cycle as the clear wins.
- R11: `status_o` layout: bits 7:0 transmit count, bits 14:8 receive count, bit 15 receive passive flag, bits 23:16 log count, bit 24 overflow flag, bit 25 bus-off, bits 31:26 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit protocol error strobe |
| rx_err_i | input | 1 | Receive protocol error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| restrict_i | input | 1 | Restricted-operation mode |
| recover_i | input | 1 | Bus-off recovery request |
| rd_log_i | input | 1 | Read strobe for the log field (clears it) |
| elo_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 7 | Receive error count (saturated) |
| log_o | output | 8 | Error log count |
| elo_irq_o | output | 1 | Sticky log-overflow interrupt flag |
| err_passive_o | output | 1 | Error-passive status |
| bus_off_o | output | 1 | Bus-off status |
| status_o | output | 32 | Packed status word |

## Verification
The embedded assertions check the following on every cycle:
- the +8 transmit step;
- the freeze of the transmit count in restricted mode and in bus-off;
- the receive saturation into the passive flag;
- log saturation and the result of a read;
- overflow flag stickiness.

The bench's scenarios are needed to show:
- bus-off entry at exactly the 32nd transmit error and recovery from it;
- passive-flag release by a receive success;
- log overflow reached through 256 restricted-mode errors;
- the read-plus-increment result of 1;
- set-over-clear priority of the flag.

A long randomized sweep then compares every output against an arithmetic model on each cycle.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int TEC_W   = 8;
  localparam int REC_W   = 7;
  localparam int LOG_W   = 8;
  localparam int TX_STEP = 8;
  localparam int STAT_W  = 32;
endpackage

// File: rtl/can_tec_ctr.sv
module can_tec_ctr #(
  parameter int W    = 8,
  parameter int STEP = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         err_i,
  input  logic         ok_i,
  input  logic         restrict_i,
  input  logic         recover_i,
  output logic [W-1:0] tec_o,
  output logic         bus_off_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W:0]   STEP_V = STEP[W:0];

  logic [W-1:0] tec_q;
  logic         boff_q;
  logic [W:0]   sum;

  assign sum = {1'b0, tec_q} + STEP_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q  <= '0;
      boff_q <= 1'b0;
    end else if (boff_q) begin
      if (recover_i) begin
        tec_q  <= '0;
        boff_q <= 1'b0;
      end
    end else if (err_i) begin
      if (!restrict_i) begin
        if (sum[W]) begin
          tec_q  <= MAX;
          boff_q <= 1'b1;
        end else begin
          tec_q <= sum[W-1:0];
        end
      end
    end else if (ok_i && tec_q != '0) begin
      tec_q <= tec_q - 1'b1;
    end
  end

  assign tec_o     = tec_q;
  assign bus_off_o = boff_q;

  assert_tec_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !restrict_i && !boff_q && !sum[W]) |=> (tec_q == $past(tec_q) + STEP_V[W-1:0]));

  assert_tec_restrict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restrict_i && err_i && !boff_q) |=> $stable(tec_q));

  assert_tec_boff_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boff_q && !recover_i) |=> ($stable(tec_q) && boff_q));
endmodule

// File: rtl/can_rec_ctr.sv
module can_rec_ctr #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         err_i,
  input  logic         ok_i,
  input  logic         restrict_i,
  input  logic         freeze_i,
  input  logic         clear_i,
  output logic [W-1:0] rec_o,
  output logic         pass_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (!freeze_i) begin
      if (err_i) begin
        if (!restrict_i) begin
          if (cnt_q == MAX) pass_q <= 1'b1;
          else              cnt_q  <= cnt_q + 1'b1;
        end
      end else if (ok_i) begin
        // passive flag stands for one step above MAX
        if (pass_q)              pass_q <= 1'b0;
        else if (cnt_q != '0)    cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign rec_o  = cnt_q;
  assign pass_o = pass_q;

  assert_rec_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !restrict_i && !freeze_i && !clear_i && cnt_q == MAX) |=> (pass_q && cnt_q == MAX));

  assert_rec_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !clear_i) |=> ($stable(cnt_q) && $stable(pass_q)));
endmodule

// File: rtl/can_log_ctr.sv
module can_log_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         rd_i,
  input  logic         clr_i,
  output logic [W-1:0] log_o,
  output logic         elo_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] log_q;
  logic         elo_q;
  logic         sat;

  assign sat = (log_q == MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_q <= '0;
    end else if (rd_i) begin
      log_q <= inc_i ? ONE : '0;
    end else if (inc_i && !sat) begin
      log_q <= log_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     elo_q <= 1'b0;
    else if (inc_i && sat && !rd_i)  elo_q <= 1'b1;
    else if (clr_i)                  elo_q <= 1'b0;
  end

  assign log_o = log_q;
  assign elo_o = elo_q;

  assert_log_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat && !rd_i) |=> (log_q == MAX));

  assert_log_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (log_q == (ONE & {W{$past(inc_i)}})));

  assert_elo_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elo_q && !clr_i) |=> elo_q);
endmodule

// File: rtl/can_err_count.sv
module can_err_count
  import can_err_pkg::*;
#(
  parameter int TW = TEC_W,
  parameter int RW = REC_W,
  parameter int LW = LOG_W,
  parameter int TS = TX_STEP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_err_i,
  input  logic              rx_err_i,
  input  logic              tx_ok_i,
  input  logic              rx_ok_i,
  input  logic              restrict_i,
  input  logic              recover_i,
  input  logic              rd_log_i,
  input  logic              elo_clr_i,
  output logic [TW-1:0]     tec_o,
  output logic [RW-1:0]     rec_o,
  output logic [LW-1:0]     log_o,
  output logic              elo_irq_o,
  output logic              err_passive_o,
  output logic              bus_off_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int PAD = STAT_W - (TW + RW + 1 + LW + 2);
  localparam logic [TW-1:0] PASS_LVL = {1'b1, {(TW-1){1'b0}}};

  logic rec_pass;
  logic log_inc;

  can_tec_ctr #(.W(TW), .STEP(TS)) u_tec (
    .clk_i, .rst_ni,
    .err_i(tx_err_i), .ok_i(tx_ok_i), .restrict_i, .recover_i,
    .tec_o, .bus_off_o
  );

  can_rec_ctr #(.W(RW)) u_rec (
    .clk_i, .rst_ni,
    .err_i(rx_err_i), .ok_i(rx_ok_i), .restrict_i,
    .freeze_i(bus_off_o), .clear_i(bus_off_o && recover_i),
    .rec_o, .pass_o(rec_pass)
  );

  assign log_inc = (tx_err_i || rx_err_i) && !bus_off_o;

  can_log_ctr #(.W(LW)) u_log (
    .clk_i, .rst_ni,
    .inc_i(log_inc), .rd_i(rd_log_i), .clr_i(elo_clr_i),
    .log_o, .elo_o(elo_irq_o)
  );

  assign err_passive_o = (tec_o >= PASS_LVL) || rec_pass;
  assign status_o = {{PAD{1'b0}}, bus_off_o, elo_irq_o, log_o, rec_pass, rec_o, tec_o};

  assert_boff_log_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && !rd_log_i) |=> $stable(log_o));

  assert_passive_tec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> err_passive_o);
endmodule

// File: tb/can_err_count_test.sv
`timescale 1ns/1ps
module can_err_count_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_e = 0, rx_e = 0, tx_k = 0, rx_k = 0, rs = 0, rcv = 0, rd = 0, clr = 0;
  logic [7:0]  tec;
  logic [6:0]  rec;
  logic [7:0]  lg;
  logic        elo, pas, boff;
  logic [31:0] st;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  int  m_tec = 0, m_rec = 0, m_log = 0;
  bit  m_pass = 0, m_elo = 0, m_boff = 0;

  always #5 clk = ~clk;

  can_err_count uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_err_i(tx_e), .rx_err_i(rx_e), .tx_ok_i(tx_k), .rx_ok_i(rx_k),
    .restrict_i(rs), .recover_i(rcv), .rd_log_i(rd), .elo_clr_i(clr),
    .tec_o(tec), .rec_o(rec), .log_o(lg), .elo_irq_o(elo),
    .err_passive_o(pas), .bus_off_o(boff), .status_o(st)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [31:0] es;
    es = {6'b0, m_boff, m_elo, m_log[7:0], m_pass, m_rec[6:0], m_tec[7:0]};
    chk("R2 R6 R7 tec", tec, m_tec);
    chk("R3 R4 R7 rec", rec, m_rec);
    chk("R8 R9 log", lg, m_log);
    chk("R10 elo", elo, m_elo);
    chk("R5 passive", pas, (m_tec >= 128) || m_pass);
    chk("R6 bus_off", boff, m_boff);
    chk("R11 status", st, es);
  endtask

  task automatic model_step();
    bit inc;
    inc = (tx_e || rx_e) && !m_boff;
    // log and flag (R8 R9 R10)
    if (inc && m_log == 255 && !rd) m_elo = 1;
    else if (clr) m_elo = 0;
    if (rd) m_log = inc ? 1 : 0;
    else if (inc && m_log < 255) m_log++;
    // counters
    if (m_boff) begin
      if (rcv) begin m_tec = 0; m_rec = 0; m_pass = 0; m_boff = 0; end
    end else begin
      if (tx_e) begin
        if (!rs) begin
          if (m_tec + 8 > 255) begin m_tec = 255; m_boff = 1; end
          else m_tec += 8;
        end
      end else if (tx_k && m_tec > 0) m_tec--;
      if (rx_e) begin
        if (!rs) begin
          if (m_rec == 127) m_pass = 1; else m_rec++;
        end
      end else if (rx_k) begin
        if (m_pass) m_pass = 0; else if (m_rec > 0) m_rec--;
      end
    end
  endtask

  task automatic step(bit te, bit re, bit tk, bit rk, bit r, bit rv, bit d, bit c);
    tx_e = te; rx_e = re; tx_k = tk; rx_k = rk; rs = r; rcv = rv; rd = d; clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", st, 0);
    chk("R1 flags", {elo, pas, boff}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R2 R6: 31 errors reach 248, the 32nd enters bus-off
    for (int i = 0; i < 31; i++) step(1,0,0,0,0,0,0,0);
    chk("R2 tec 248", tec, 248);
    step(1,0,0,0,0,0,0,0);
    chk("R6 bus_off entry", {boff, tec}, {1'b1, 8'd255});
    for (int i = 0; i < 4; i++) step(1,1,1,1,0,0,0,0);  // frozen in bus-off
    step(0,0,0,0,0,1,0,0);
    chk("R6 recovered", {boff, tec}, 0);
    step(0,0,0,0,0,1,0,0);  // recovery outside bus-off: no effect
    step(0,0,1,0,0,0,0,0);  // floor at 0 (R2)

    // R3 R4: receive saturation and passive flag
    for (int i = 0; i < 130; i++) step(0,1,0,0,0,0,0,0);
    chk("R4 passive flag", {st[15], rec, pas}, {1'b1, 7'd127, 1'b1});
    step(0,0,0,1,0,0,0,0);
    chk("R4 flag release", {st[15], rec}, {1'b0, 7'd127});
    step(0,0,0,1,0,0,0,0);
    chk("R3 rec dec", rec, 126);
    step(0,1,0,1,0,0,0,0);  // error wins over success

    // R7 R8 R10: restricted errors saturate log, then overflow
    step(0,0,0,0,0,0,1,0);
    for (int i = 0; i < 256; i++) step(i[0], ~i[0] | i[1], 0, 0, 1, 0, 0, 0);
    chk("R7 counts held", {tec, rec}, {8'd0, 7'd127});
    chk("R10 overflow", {lg, elo}, {8'hFF, 1'b1});
    step(0,1,0,0,1,0,0,1);   // set beats clear
    chk("R10 set wins", elo, 1);
    step(0,0,0,0,0,0,0,1);
    chk("R10 cleared", elo, 0);
    step(1,1,0,0,1,0,1,0);   // R9 read with increment
    chk("R9 read+inc", lg, 1);
    step(0,0,0,0,0,0,1,0);
    chk("R9 read", lg, 0);

    // randomized sweep against model
    for (int i = 0; i < 20000; i++) begin
      step($urandom_range(0,7) == 0, $urandom_range(0,3) == 0,
           $urandom_range(0,2) == 0, $urandom_range(0,2) == 0,
           $urandom_range(0,5) == 0, $urandom_range(0,15) == 0,
           $urandom_range(0,299) == 0, $urandom_range(0,63) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule